// File: doc/BRIEF.md
# Fractional Reference Clock Divider

This block makes a reference clock from one of three source signals, dividing it by an integer plus a fraction in 1/512 steps. The half-period of the output lasts DIV source periods. A 9-bit accumulator adds one extra source period to a half whenever it carries, so the long-run output period is 2*(DIV + TRIM/512) source periods. All logic runs on one fast clock `clk_i`. The sources arrive as levels sampled in that clock, and a rising edge of the selected level is one source period.

Software writes a control word and a trim word. Both have plain, set-mask and clear-mask addresses. New source, divisor and trim values are only staged. They reach the divider when the switch bit is requested, and only at an output period boundary, so the output never shows a shortened pulse. The switch bit clears itself once the values have been loaded, and a read-only busy bit mirrors it. When the generator is off or its output is disabled, the output is held low and the divider state is cleared.

Top module: `refclk_frac_div`

## Requirements
- R1: After reset the control word (byte offset 0x00) and the trim word (byte offset 0x10) both read 0 and `ref_clk_o` is low.
- R2: Control word layout: source select [3:0], busy flag [8] (read-only, writes ignored), switch request [9], output enable [12], generator on [15], integer divisor DIV [30:16]. Trim word: TRIM in [31:23]. All other bits read 0.
- R3: Offsets 0x04 and 0x14 clear the bits set in the write data, and 0x08 and 0x18 set them. All other bits keep their values. Writing through the clear-mask address never clears the switch request.
- R4: Writes to source select, DIV and TRIM leave the running output unchanged until a switch is requested and taken.
- R5: Writing 1 to bit 9 (plain or set address) requests a switch. Bits 9 and 8 read 1 until the staged values are loaded. Loading happens on the falling output edge that ends a period, in the cycle after the output reads low in bypass, or in the next cycle while the generator is stopped. A selected source that never toggles therefore holds the request until the generator is stopped.
- R6: With TRIM=0 and DIV>0, each output half-period lasts exactly DIV rising edges of the selected source.
- R7: With TRIM>0, the extra source period is added to a half whenever the 9-bit accumulator (TRIM added once per half, cleared at a switch) overflows. Any 2*512/gcd span of halves has the exact average.
- R8: Source codes: 0 selects `sys_src_i`, 7 selects `pll_src_i`, 8 selects `ext_src_i`. Every other code selects a constant low, and the output stays low.
- R9: With DIV=0 the output follows the selected source level with one `clk_i` cycle of latency.
- R10: When bit 15 or bit 12 is 0, `ref_clk_o` is low in the same cycle, and the divider counters and accumulator are cleared.
- R11: In divide mode the output changes only on a rising edge of the selected source, or goes low at a switch, so no half-period is shorter than DIV source periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Byte offset of the register access |
| reg_wdata_i | input | 32 | Write data or bit mask |
| reg_rdata_o | output | 32 | Control word for offsets below 0x10, else the trim word |
| sys_src_i | input | 1 | System clock source level (code 0) |
| pll_src_i | input | 1 | PLL source level (code 7) |
| ext_src_i | input | 1 | External reference level (code 8) |
| ref_clk_o | output | 1 | Divided reference clock |

## Verification
A register write is captured on one rising edge and can be read back at the following falling edge. A pending switch, though, clears only on the edge after its boundary, so the bench reads the busy bits a few cycles after a write and again well past the next period. Bypass output is compared each falling edge against the source level captured at the previous rising edge, which matches its one-cycle latency. Divide ratios are checked as cycle counts between output rising edges taken several periods after a switch. This makes them independent of pipeline offset and of the transient when the source changes.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int SEL_W  = 4;
  localparam int DIV_W  = 15;
  localparam int TRIM_W = 9;
  localparam int N_SRC  = 3;

  localparam int SEL_LSB  = 0;
  localparam int ACT_BIT  = 8;
  localparam int SW_BIT   = 9;
  localparam int OE_BIT   = 12;
  localparam int ON_BIT   = 15;
  localparam int DIV_LSB  = 16;
  localparam int TRIM_LSB = 23;

  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h7FFF_900F;
  localparam logic [DATA_W-1:0] TRIM_WMASK = 32'hFF80_0000;

  localparam logic [ADDR_W-1:0] OFS_CTRL     = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL_CLR = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL_SET = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_TRIM     = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_TRIM_CLR = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_TRIM_SET = 5'h18;

  localparam logic [SEL_W-1:0] SRC_SYS = 4'd0;
  localparam logic [SEL_W-1:0] SRC_PLL = 4'd7;
  localparam logic [SEL_W-1:0] SRC_EXT = 4'd8;

  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_CLR, OP_SET} reg_op_e;

  function automatic logic [SEL_W-1:0] src_code(input int idx);
    case (idx)
      0:       return SRC_SYS;
      1:       return SRC_PLL;
      default: return SRC_EXT;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_merge(input reg_op_e op,
                                                  input logic [DATA_W-1:0] old,
                                                  input logic [DATA_W-1:0] w);
    case (op)
      OP_WRITE: return w;
      OP_CLR:   return old & ~w;
      OP_SET:   return old | w;
      default:  return old;
    endcase
  endfunction
endpackage

// File: rtl/refclk_regs.sv
module refclk_regs
  import refclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              apply_i,
  output logic [DATA_W-1:0] ctrl_img_o,
  output logic [DATA_W-1:0] trim_img_o,
  output logic              sw_set_o,
  output logic              sw_o,
  output logic              on_o,
  output logic              oe_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [TRIM_W-1:0] trim_o
);
  reg_op_e ctrl_op, trim_op;
  logic [DATA_W-1:0] ctrl_q, trim_q;
  logic sw_q;

  always_comb begin
    ctrl_op = OP_NONE;
    trim_op = OP_NONE;
    if (we_i) begin
      unique case (addr_i)
        OFS_CTRL:     ctrl_op = OP_WRITE;
        OFS_CTRL_CLR: ctrl_op = OP_CLR;
        OFS_CTRL_SET: ctrl_op = OP_SET;
        OFS_TRIM:     trim_op = OP_WRITE;
        OFS_TRIM_CLR: trim_op = OP_CLR;
        OFS_TRIM_SET: trim_op = OP_SET;
        default: ;
      endcase
    end
  end

  // request only from plain or set access; clear alias cannot cancel it
  assign sw_set_o = ((ctrl_op == OP_WRITE) || (ctrl_op == OP_SET)) && wdata_i[SW_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      trim_q <= '0;
      sw_q   <= 1'b0;
    end else begin
      if (ctrl_op != OP_NONE) ctrl_q <= reg_merge(ctrl_op, ctrl_q, wdata_i) & CTRL_WMASK;
      if (trim_op != OP_NONE) trim_q <= reg_merge(trim_op, trim_q, wdata_i) & TRIM_WMASK;
      sw_q <= sw_set_o | (sw_q & ~apply_i);
    end
  end

  always_comb begin
    ctrl_img_o          = ctrl_q;
    ctrl_img_o[SW_BIT]  = sw_q;
    ctrl_img_o[ACT_BIT] = sw_q;
  end

  assign trim_img_o = trim_q;
  assign sw_o       = sw_q;
  assign on_o       = ctrl_q[ON_BIT];
  assign oe_o       = ctrl_q[OE_BIT];
  assign sel_o      = ctrl_q[SEL_LSB +: SEL_W];
  assign div_o      = ctrl_q[DIV_LSB +: DIV_W];
  assign trim_o     = trim_q[TRIM_LSB +: TRIM_W];
endmodule

// File: rtl/refclk_src_sel.sv
module refclk_src_sel
  import refclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             lvl_o,
  output logic             tick_o
);
  logic [N_SRC-1:0] hit;
  logic lvl_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_hit
    assign hit[g] = (sel_i == src_code(g));
  end

  assign lvl_o = |(hit & src_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_o;
  end

  assign tick_o = lvl_o & ~lvl_q;
endmodule

// File: rtl/refclk_frac_engine.sv
module refclk_frac_engine #(
  parameter int DIV_W  = 15,
  parameter int TRIM_W = 9,
  parameter int SEL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              sw_i,
  input  logic [SEL_W-1:0]  stg_sel_i,
  input  logic [DIV_W-1:0]  stg_div_i,
  input  logic [TRIM_W-1:0] stg_trim_i,
  input  logic              lvl_i,
  input  logic              tick_i,
  output logic              apply_o,
  output logic              out_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [DIV_W:0]    cnt_o,
  output logic              ext_o
);
  localparam int LEN_W = DIV_W + 1;

  logic [DIV_W-1:0]  div_q;
  logic [TRIM_W-1:0] trim_q, acc_q;
  logic [SEL_W-1:0]  sel_q;
  logic [LEN_W-1:0]  cnt_q, len;
  logic [TRIM_W:0]   acc_sum;
  logic ext_q, out_q, bypass, half_end, boundary;

  assign bypass   = (div_q == '0);
  assign len      = {1'b0, div_q} + LEN_W'(ext_q);
  assign half_end = tick_i && ((cnt_q + 1'b1) == len);
  assign acc_sum  = {1'b0, acc_q} + {1'b0, trim_q};

  // period boundary: falling edge in divide mode, low level in bypass
  assign boundary = !run_i || (bypass ? !out_q : (half_end && out_q));
  assign apply_o  = sw_i && boundary;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0; trim_q <= '0; sel_q <= '0;
      cnt_q <= '0; acc_q <= '0; ext_q <= 1'b0; out_q <= 1'b0;
    end else if (apply_o) begin
      div_q <= stg_div_i; trim_q <= stg_trim_i; sel_q <= stg_sel_i;
      cnt_q <= '0; acc_q <= '0; ext_q <= 1'b0; out_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0; acc_q <= '0; ext_q <= 1'b0; out_q <= 1'b0;
    end else if (bypass) begin
      cnt_q <= '0;
      out_q <= lvl_i;
    end else if (tick_i) begin
      if (half_end) begin
        out_q <= ~out_q;
        cnt_q <= '0;
        acc_q <= acc_sum[TRIM_W-1:0];
        ext_q <= acc_sum[TRIM_W];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign out_o = out_q;
  assign sel_o = sel_q;
  assign div_o = div_q;
  assign cnt_o = cnt_q;
  assign ext_o = ext_q;
endmodule

// File: rtl/refclk_frac_div.sv
module refclk_frac_div
  import refclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              sys_src_i,
  input  logic              pll_src_i,
  input  logic              ext_src_i,
  output logic              ref_clk_o
);
  logic [DATA_W-1:0] ctrl_img, trim_img;
  logic sw_set, sw_q, on, oe, run, apply, lvl, tick, out_q, ext;
  logic [SEL_W-1:0]  stg_sel, sel_act;
  logic [DIV_W-1:0]  stg_div, div_act;
  logic [TRIM_W-1:0] stg_trim;
  logic [DIV_W:0]    cnt;

  refclk_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .apply_i(apply),
    .ctrl_img_o(ctrl_img), .trim_img_o(trim_img),
    .sw_set_o(sw_set), .sw_o(sw_q), .on_o(on), .oe_o(oe),
    .sel_o(stg_sel), .div_o(stg_div), .trim_o(stg_trim)
  );

  refclk_src_sel u_src (
    .clk_i, .rst_ni,
    .src_i({ext_src_i, pll_src_i, sys_src_i}),
    .sel_i(sel_act), .lvl_o(lvl), .tick_o(tick)
  );

  refclk_frac_engine #(.DIV_W(DIV_W), .TRIM_W(TRIM_W), .SEL_W(SEL_W)) u_eng (
    .clk_i, .rst_ni,
    .run_i(run), .sw_i(sw_q),
    .stg_sel_i(stg_sel), .stg_div_i(stg_div), .stg_trim_i(stg_trim),
    .lvl_i(lvl), .tick_i(tick),
    .apply_o(apply), .out_o(out_q), .sel_o(sel_act), .div_o(div_act),
    .cnt_o(cnt), .ext_o(ext)
  );

  assign run         = on & oe;
  assign ref_clk_o   = out_q & run;
  assign reg_rdata_o = reg_addr_i[ADDR_W-1] ? trim_img : ctrl_img;
endmodule

// File: rtl/refclk_frac_div_chk.sv
module refclk_frac_div_chk
  import refclk_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run,
  input logic              apply,
  input logic              sw_set,
  input logic              sw_q,
  input logic              tick,
  input logic              out_q,
  input logic              ref_clk_o,
  input logic [DIV_W-1:0]  div_act,
  input logic [DIV_W:0]    cnt,
  input logic              ext,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] ctrl_img
);
  localparam logic [DATA_W-1:0] MASK_NOSW = CTRL_WMASK;

  a_r10_stopped_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !ref_clk_o);

  a_r5_sw_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply && !sw_set) |=> !sw_q);

  a_r5_sw_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_q && !apply) |=> sw_q);

  a_r11_edge_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run) && !$past(apply) && ($past(div_act) != '0) && (out_q != $past(out_q)))
      |-> $past(tick));

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_act != '0) |-> (cnt < ({1'b0, div_act} + {{DIV_W{1'b0}}, ext})));

  a_r3_set_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_CTRL_SET)
      |=> ((ctrl_img & $past(reg_wdata_i) & MASK_NOSW) == ($past(reg_wdata_i) & MASK_NOSW)));

  a_r3_clr_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_CTRL_CLR)
      |=> ((ctrl_img & $past(reg_wdata_i) & MASK_NOSW) == '0));
endmodule

bind refclk_frac_div refclk_frac_div_chk u_chk (
  .clk_i, .rst_ni, .run, .apply, .sw_set, .sw_q, .tick, .out_q, .ref_clk_o,
  .div_act, .cnt, .ext, .reg_we_i, .reg_addr_i, .reg_wdata_i, .ctrl_img
);

// File: tb/sim_refclk_frac_div.sv
module sim_refclk_frac_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic sys_src = 1'b0, pll_src = 1'b0, ext_src = 1'b0;
  logic ref_clk;
  logic pll_seen = 1'b0;
  int checks = 0;
  int failures = 0;
  int phase = 0;

  localparam logic [31:0] ON = 32'h8000, OE = 32'h1000, SW = 32'h0200;

  refclk_frac_div u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sys_src_i(sys_src),
    .pll_src_i(pll_src), .ext_src_i(ext_src), .ref_clk_o(ref_clk)
  );

  always #2 clk = ~clk;

  // sources: sys period 2, ext period 4, pll period 6 clk cycles
  always @(posedge clk) begin
    #1;
    phase++;
    sys_src = ~sys_src;
    if (phase % 2 == 0) ext_src = ~ext_src;
    if (phase % 3 == 0) pll_src = ~pll_src;
  end

  always @(posedge clk) pll_seen <= pll_src;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sync_fall();
    logic prev = ref_clk;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (prev && !ref_clk) break;
      prev = ref_clk;
    end
  endtask

  // cycles across n rising-edge intervals and shortest level run
  task automatic measure(input int n, output int total, output int minh);
    logic prev = ref_clk;
    int seg = 0, rises = 0, guard = 0;
    total = 0; minh = 100000;
    while (!(!prev && ref_clk) && guard < 2000) begin
      prev = ref_clk; @(negedge clk); guard++;
    end
    prev = ref_clk;
    while (rises < n && guard < 4000) begin
      @(negedge clk); guard++; total++; seg++;
      if (ref_clk != prev) begin
        if (seg < minh) minh = seg;
        seg = 0;
        if (ref_clk) rises++;
      end
      prev = ref_clk;
    end
    if (guard >= 4000 || rises < n) total = -1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(5'h00, d); chk("R1 ctrl", d, 0);
    reg_rd(5'h10, d); chk("R1 trim", d, 0);
    chk("R1 out", ref_clk, 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    reg_wr(5'h00, 32'hFFFF_FDFF);
    reg_rd(5'h00, d); chk("R2 ctrl fields, bit8 ignored", d, 32'h7FFF_900F);
    reg_wr(5'h10, 32'hFFFF_FFFF);
    reg_rd(5'h10, d); chk("R2 trim field", d, 32'hFF80_0000);
    reg_wr(5'h00, 0); reg_wr(5'h10, 0);
  endtask

  task automatic t_alias();
    logic [31:0] d;
    reg_wr(5'h08, 32'h0003_0000);
    reg_rd(5'h00, d); chk("R3 ctrl set", d, 32'h0003_0000);
    reg_wr(5'h04, 32'h0001_0000);
    reg_rd(5'h00, d); chk("R3 ctrl clr", d, 32'h0002_0000);
    reg_wr(5'h18, 32'h0100_0000);
    reg_rd(5'h10, d); chk("R3 trim set", d, 32'h0100_0000);
    reg_wr(5'h14, 32'hFFFF_FFFF);
    reg_rd(5'h10, d); chk("R3 trim clr", d, 0);
    reg_wr(5'h00, 0);
  endtask

  task automatic t_switch_off();
    logic [31:0] d;
    reg_wr(5'h00, (3 << 16) | SW);
    reg_rd(5'h00, d); chk("R5 pending flags", d, 32'h0003_0300);
    wait_clk(1);
    reg_rd(5'h00, d); chk("R5 cleared while stopped", d, 32'h0003_0000);
  endtask

  task automatic t_int_div();
    int tot, mh;
    reg_wr(5'h08, ON | OE);
    wait_clk(20);
    measure(2, tot, mh);
    chk("R6 div3 period", tot, 24);
    chk("R11 div3 min half", mh, 6);
  endtask

  task automatic t_staging();
    logic [31:0] d;
    int tot, mh;
    reg_wr(5'h00, ON | OE | (5 << 16));
    wait_clk(30);
    measure(2, tot, mh); chk("R4 div staged only", tot, 24);
    reg_wr(5'h10, 32'h8000_0000);
    measure(1, tot, mh); chk("R4 trim staged only", tot, 12);
    reg_wr(5'h10, 0);
    sync_fall();
    reg_wr(5'h08, SW);
    wait_clk(4);
    reg_rd(5'h00, d); chk("R5 held until boundary", d, 32'h0005_9300);
    wait_clk(30);
    reg_rd(5'h00, d); chk("R5 cleared after boundary", d, 32'h0005_9000);
    measure(2, tot, mh); chk("R6 div5 period", tot, 40);
  endtask

  task automatic t_frac();
    int tot, mh;
    reg_wr(5'h10, 32'h8000_0000);
    reg_wr(5'h08, SW);
    wait_clk(60);
    measure(4, tot, mh);
    chk("R7 trim256 four periods", tot, 88);
    chk("R11 trim256 min half", mh, 10);
    reg_wr(5'h10, 32'h4000_0000);
    reg_wr(5'h08, SW);
    wait_clk(60);
    measure(4, tot, mh);
    chk("R7 trim128 four periods", tot, 84);
  endtask

  task automatic t_sources();
    logic [31:0] d;
    int tot, mh, highs;
    reg_wr(5'h10, 0);
    reg_wr(5'h00, ON | OE | SW | (2 << 16) | 8);
    wait_clk(60);
    measure(2, tot, mh); chk("R8 ext source", tot, 32);
    reg_wr(5'h00, ON | OE | SW | (1 << 16) | 7);
    wait_clk(60);
    measure(2, tot, mh); chk("R8 pll source", tot, 24);
    reg_wr(5'h00, ON | OE | SW | (2 << 16) | 3);
    wait_clk(60);
    highs = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (ref_clk) highs++; end
    chk("R8 unused code gives no clock", highs, 0);
    reg_wr(5'h00, ON | OE | SW | 7);
    wait_clk(40);
    reg_rd(5'h00, d); chk("R5 stalled source holds request", d, 32'h0000_9307);
    reg_wr(5'h04, ON);
    wait_clk(3);
    reg_rd(5'h00, d); chk("R5 taken once stopped", d, 32'h0000_1007);
  endtask

  task automatic t_bypass();
    int bad = 0;
    reg_wr(5'h08, ON);
    wait_clk(10);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (ref_clk !== pll_seen) bad++;
    end
    chk("R9 bypass follows pll one cycle late", bad, 0);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    int highs = 0;
    reg_wr(5'h04, OE);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (ref_clk) highs++; end
    chk("R10 oe clear holds low", highs, 0);
    reg_rd(5'h00, d); chk("R10 ctrl after oe clear", d, 32'h0000_8007);
    reg_wr(5'h08, OE);
    reg_wr(5'h04, ON);
    highs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (ref_clk) highs++; end
    chk("R10 off holds low", highs, 0);
  endtask

  initial begin
    #20000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    t_reset();
    t_layout();
    t_alias();
    t_switch_off();
    t_int_div();
    t_staging();
    t_frac();
    t_sources();
    t_bypass();
    t_stop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule